// File: doc/BRIEF.md
# Masked Complement Test Executor

This block runs one instruction from an 8-bit microcontroller's instruction set: a non-destructive bit test. The test inverts a destination byte and ANDs it with a mask byte. The outcome goes only to the status flags. A zero result means every masked bit of the destination was one. The block accepts a start pulse and a program address. It then pulls instruction bytes one per clock from a byte fetch port and decodes one of five addressing forms. It gathers both operands from a private 256-byte register file and raises a one-cycle completion pulse after the fixed cycle count of that form.

Operands come from three kinds of source. A working register is named by a 4-bit index inside a 16-byte page, and an input selects that page. A full register address can be carried in an instruction byte. The mask can also be an immediate byte, or it can be fetched indirectly through a register that holds its address. The register file has one write port, used by the surrounding core and by the testbench to preload contents, and one observation read port. The instruction never writes either operand.

Top module: `tcm_exec`

## Requirements
- R1: At completion, Z (flags bit 4) is 1 when (NOT destination) AND mask is zero, and 0 otherwise.
- R2: At completion, S (flags bit 3) equals bit 7 of (NOT destination) AND mask.
- R3: At completion, V (flags bit 2) is 0. C (bit 5), D (bit 1) and H (bit 0) keep the values they had before the instruction.
- R4: Opcode 0x62 is two bytes long. The second byte holds the destination working-register index in bits 7:4 and the mask working-register index in bits 3:0. done is high in cycle 4, where cycle 1 is the cycle after start is sampled.
- R5: Opcode 0x63 is two bytes long with the same second-byte layout as R4. The register named by bits 3:0 holds the register-file address of the mask. done is high in cycle 6.
- R6: Opcode 0x64 is three bytes long. Byte 2 is the mask register address and byte 3 is the destination register address. done is high in cycle 6.
- R7: Opcode 0x65 is three bytes long. Byte 2 is the address of a register holding the mask's address, and byte 3 is the destination address. done is high in cycle 6.
- R8: Opcode 0x66 is three bytes long. Byte 2 is the destination address and byte 3 is the immediate mask. done is high in cycle 6.
- R9: A working-register index i maps to register-file address {wr_page, i}.
- R10: After the instruction, the destination and mask register contents are unchanged.
- R11: Any opcode other than 0x62 to 0x66 makes illegal high for exactly cycle 2. done does not rise, the flags are unchanged, and the block returns to idle.
- R12: done is a single-cycle pulse. The new flag values appear on flags in that same cycle, and busy is high from cycle 1 until that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction (sampled when idle) |
| start_addr | input | 16 | Address of the opcode byte |
| fetch_addr | output | 16 | Address of the byte being fetched |
| fetch_data | input | 8 | Byte at fetch_addr, same cycle |
| wr_page | input | 4 | Working-register page (upper address nibble) |
| rf_we | input | 1 | Register-file write enable |
| rf_waddr | input | 8 | Register-file write address |
| rf_wdata | input | 8 | Register-file write data |
| obs_addr | input | 8 | Register-file observation address |
| obs_data | output | 8 | Register-file contents at obs_addr |
| flag_we | input | 1 | Load flags from flag_wdata |
| flag_wdata | input | 6 | Flag load value {C,Z,S,V,D,H} |
| flags | output | 6 | Status flags {C,Z,S,V,D,H} |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Unsupported opcode pulse |

## Verification
Every form is run with destination and mask pairs chosen to separate the flag rules. Some pairs make the masked bits all one in the destination, so Z is set. Some leave a masked bit clear at bit 7, so S is set while Z stays clear. Others use an all-zero mask, a fully set destination, or disjoint bit patterns. Preloaded flag values alternate between all-ones and sparse patterns, so the tests tell a correctly preserved C, D or H apart from a cleared or stuck bit. They also show that V is cleared even when it starts at one. The working-register page is varied so that a wrong address mapping reads the wrong operand. Reading the operands back after each instruction exposes any stray write.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_BYTE2,
        ST_BYTE3,
        ST_INDIR,
        ST_EXEC
    } state_e;

    // Addressing form of the instruction
    typedef enum logic [2:0] {
        FORM_WW,    // working reg, working reg
        FORM_WIW,   // working reg, indirect working reg
        FORM_RR,    // reg, reg
        FORM_RIR,   // reg, indirect reg
        FORM_RIM,   // reg, immediate
        FORM_BAD
    } form_e;

    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic v;
        logic d;
        logic h;
    } flags_t;

    localparam logic [7:0] OPC_FIRST = 8'h62;

endpackage

// File: rtl/tcm_regfile.sv
module tcm_regfile #(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] ra0,
    output logic [DW-1:0] rd0,
    input  logic [AW-1:0] ra1,
    output logic [DW-1:0] rd1,
    input  logic [AW-1:0] ra2,
    output logic [DW-1:0] rd2
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rd0 = mem_q[ra0];
    assign rd1 = mem_q[ra1];
    assign rd2 = mem_q[ra2];

endmodule

// File: rtl/tcm_decode.sv
module tcm_decode
    import tcm_pkg::*;
#(
    parameter int CNT_W     = 3,
    parameter int CYC_SHORT = 4,
    parameter int CYC_LONG  = 6
) (
    input  logic [7:0]       opcode,
    output form_e            form,
    output logic             legal,
    output logic [CNT_W-1:0] cycles
);
    logic [7:0] rel;

    always_comb begin
        rel    = opcode - OPC_FIRST;
        legal  = 1'b1;
        cycles = CNT_W'(CYC_LONG);
        unique case (rel)
            8'd0: begin
                form   = FORM_WW;
                cycles = CNT_W'(CYC_SHORT);
            end
            8'd1:    form = FORM_WIW;
            8'd2:    form = FORM_RR;
            8'd3:    form = FORM_RIR;
            8'd4:    form = FORM_RIM;
            default: begin
                form  = FORM_BAD;
                legal = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tcm_flag_alu.sv
module tcm_flag_alu
    import tcm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] dst,
    input  logic [DW-1:0] mask,
    input  flags_t        fl_in,
    output flags_t        fl_out
);
    logic [DW-1:0] res;

    always_comb begin
        res      = ~dst & mask;
        fl_out   = fl_in;
        fl_out.z = ~|res;
        fl_out.s = res[DW-1];
        fl_out.v = 1'b0;
    end

endmodule

// File: rtl/tcm_exec.sv
module tcm_exec
    import tcm_pkg::*;
#(
    parameter int PC_W      = 16,
    parameter int DW        = 8,
    parameter int RF_AW     = 8,
    parameter int CYC_SHORT = 4,
    parameter int CYC_LONG  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [PC_W-1:0]     start_addr,
    output logic [PC_W-1:0]     fetch_addr,
    input  logic [DW-1:0]       fetch_data,
    input  logic [RF_AW/2-1:0]  wr_page,
    input  logic                rf_we,
    input  logic [RF_AW-1:0]    rf_waddr,
    input  logic [DW-1:0]       rf_wdata,
    input  logic [RF_AW-1:0]    obs_addr,
    output logic [DW-1:0]       obs_data,
    input  logic                flag_we,
    input  logic [5:0]          flag_wdata,
    output logic [5:0]          flags,
    output logic                busy,
    output logic                done,
    output logic                illegal
);
    localparam int NIB   = RF_AW / 2;
    localparam int CNT_W = $clog2(CYC_LONG + 1);

    typedef struct packed {
        state_e            st;
        form_e             form;
        logic [PC_W-1:0]   pc;
        logic [CNT_W-1:0]  cyc;
        logic [CNT_W-1:0]  last;
        logic [RF_AW-1:0]  dst_a;
        logic [RF_AW-1:0]  src_a;
        logic [DW-1:0]     imm;
        logic              done;
        logic              illegal;
        flags_t            fl;
    } ctx_t;

    ctx_t ctx_q, ctx_d;

    form_e            dec_form;
    logic             dec_legal;
    logic [CNT_W-1:0] dec_cycles;

    tcm_decode #(
        .CNT_W    (CNT_W),
        .CYC_SHORT(CYC_SHORT),
        .CYC_LONG (CYC_LONG)
    ) decode_i (
        .opcode(fetch_data[7:0]),
        .form  (dec_form),
        .legal (dec_legal),
        .cycles(dec_cycles)
    );

    logic [RF_AW-1:0] ra0, ra1;
    logic [DW-1:0]    rd0, rd1;

    tcm_regfile #(
        .DW(DW),
        .AW(RF_AW)
    ) regfile_i (
        .clk  (clk),
        .we   (rf_we),
        .waddr(rf_waddr),
        .wdata(rf_wdata),
        .ra0  (ra0),
        .rd0  (rd0),
        .ra1  (ra1),
        .rd1  (rd1),
        .ra2  (obs_addr),
        .rd2  (obs_data)
    );

    logic [DW-1:0] mask_val;
    flags_t        alu_fl;

    assign mask_val = (ctx_q.form == FORM_RIM) ? ctx_q.imm : rd1;

    tcm_flag_alu #(
        .DW(DW)
    ) alu_i (
        .dst   (rd0),
        .mask  (mask_val),
        .fl_in (ctx_q.fl),
        .fl_out(alu_fl)
    );

    always_comb begin
        ctx_d         = ctx_q;
        ctx_d.done    = 1'b0;
        ctx_d.illegal = 1'b0;
        ra0           = ctx_q.dst_a;
        ra1           = ctx_q.src_a;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctx_d.st  = ST_OPC;
                    ctx_d.pc  = start_addr;
                    ctx_d.cyc = CNT_W'(1);
                end
            end
            ST_OPC: begin
                ctx_d.pc   = ctx_q.pc + 1'b1;
                ctx_d.cyc  = ctx_q.cyc + 1'b1;
                ctx_d.form = dec_form;
                ctx_d.last = dec_cycles;
                if (dec_legal) begin
                    ctx_d.st = ST_BYTE2;
                end else begin
                    ctx_d.st      = ST_IDLE;
                    ctx_d.illegal = 1'b1;
                end
            end
            ST_BYTE2: begin
                ctx_d.pc  = ctx_q.pc + 1'b1;
                ctx_d.cyc = ctx_q.cyc + 1'b1;
                unique case (ctx_q.form)
                    FORM_WW, FORM_WIW: begin
                        ctx_d.dst_a = {wr_page, fetch_data[2*NIB-1:NIB]};
                        ctx_d.src_a = {wr_page, fetch_data[NIB-1:0]};
                        ctx_d.st    = (ctx_q.form == FORM_WIW) ? ST_INDIR : ST_EXEC;
                    end
                    FORM_RR, FORM_RIR: begin
                        ctx_d.src_a = fetch_data[RF_AW-1:0];
                        ctx_d.st    = ST_BYTE3;
                    end
                    default: begin
                        ctx_d.dst_a = fetch_data[RF_AW-1:0];
                        ctx_d.st    = ST_BYTE3;
                    end
                endcase
            end
            ST_BYTE3: begin
                ctx_d.pc  = ctx_q.pc + 1'b1;
                ctx_d.cyc = ctx_q.cyc + 1'b1;
                if (ctx_q.form == FORM_RIM) begin
                    ctx_d.imm = fetch_data;
                    ctx_d.st  = ST_EXEC;
                end else begin
                    ctx_d.dst_a = fetch_data[RF_AW-1:0];
                    ctx_d.st    = (ctx_q.form == FORM_RIR) ? ST_INDIR : ST_EXEC;
                end
            end
            ST_INDIR: begin
                ra0         = ctx_q.src_a;
                ctx_d.src_a = rd0[RF_AW-1:0];
                ctx_d.cyc   = ctx_q.cyc + 1'b1;
                ctx_d.st    = ST_EXEC;
            end
            default: begin
                if (ctx_q.cyc == ctx_q.last - 1'b1) begin
                    ctx_d.fl   = alu_fl;
                    ctx_d.done = 1'b1;
                    ctx_d.st   = ST_IDLE;
                end else begin
                    ctx_d.cyc = ctx_q.cyc + 1'b1;
                end
            end
        endcase
        if (flag_we && !ctx_d.done) begin
            ctx_d.fl = flags_t'(flag_wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{st: ST_IDLE, form: FORM_BAD, default: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign fetch_addr = ctx_q.pc;
    assign flags      = ctx_q.fl;
    assign busy       = (ctx_q.st != ST_IDLE);
    assign done       = ctx_q.done;
    assign illegal    = ctx_q.illegal;

    // Independent cycle counter and opcode capture for the timing check
    logic [CNT_W-1:0] chk_cnt_q;
    logic [7:0]       chk_opc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_cnt_q <= '0;
            chk_opc_q <= '0;
        end else begin
            if (!busy && start) begin
                chk_cnt_q <= CNT_W'(1);
            end else if (chk_cnt_q != {CNT_W{1'b1}}) begin
                chk_cnt_q <= chk_cnt_q + 1'b1;
            end
            if (busy && chk_cnt_q == CNT_W'(1)) begin
                chk_opc_q <= fetch_data[7:0];
            end
        end
    end

    // R4 R5 R6 R7 R8: completion lands on the form's cycle count
    assert_cycle_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> chk_cnt_q == ((chk_opc_q == OPC_FIRST) ? CNT_W'(CYC_SHORT) : CNT_W'(CYC_LONG)));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_keep_cdh_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!flags[2] && flags[5] == $past(flags[5])
                  && flags[1] == $past(flags[1]) && flags[0] == $past(flags[0])));

    assert_illegal_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal && !$past(flag_we)) |-> flags == $past(flags));

    assert_excl_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, illegal}));

    assert_illegal_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !busy);

endmodule

// File: tb/tcm_exec_tb_top.sv
`timescale 1ns/1ps
module tcm_exec_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] start_addr = 16'h0010;
    logic [15:0] fetch_addr;
    logic [7:0]  fetch_data;
    logic [3:0]  wr_page = 4'h0;
    logic        rf_we = 1'b0;
    logic [7:0]  rf_waddr = '0;
    logic [7:0]  rf_wdata = '0;
    logic [7:0]  obs_addr = '0;
    logic [7:0]  obs_data;
    logic        flag_we = 1'b0;
    logic [5:0]  flag_wdata = '0;
    logic [5:0]  flags;
    logic        busy, done, illegal;

    logic [7:0] prog [4];

    always #4 clk = ~clk;

    assign fetch_data = (fetch_addr[15:2] == 14'h4) ? prog[fetch_addr[1:0]] : 8'hFF;

    tcm_exec dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .fetch_addr(fetch_addr), .fetch_data(fetch_data), .wr_page(wr_page),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .obs_addr(obs_addr), .obs_data(obs_data),
        .flag_we(flag_we), .flag_wdata(flag_wdata), .flags(flags),
        .busy(busy), .done(done), .illegal(illegal)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic rf_put(input logic [7:0] a, input logic [7:0] d);
        rf_we = 1'b1; rf_waddr = a; rf_wdata = d;
        @(negedge clk);
        rf_we = 1'b0;
    endtask

    task automatic flags_put(input logic [5:0] f);
        flag_we = 1'b1; flag_wdata = f;
        @(negedge clk);
        flag_we = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] d);
        obs_addr = a;
        #1;
        d = obs_data;
    endtask

    // Start an instruction, return the cycle in which done rose and flags then
    task automatic run(output int cyc, output logic [5:0] fl, output logic busy_ok);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        busy_ok = 1'b1;
        while (!done && cyc < 12) begin
            if (!busy) busy_ok = 1'b0;
            @(negedge clk);
            cyc++;
        end
        fl = flags;
    endtask

    // {opcode, page, destination, mask, initial flags}
    localparam int NV = 12;
    localparam logic [37:0] VEC [NV] = '{
        {8'h62, 4'h5, 8'hC7, 8'h02, 6'h00},
        {8'h62, 4'hE, 8'h00, 8'h80, 6'h3F},
        {8'h63, 4'h5, 8'hC7, 8'h02, 6'h21},
        {8'h63, 4'h2, 8'h0F, 8'hF0, 6'h12},
        {8'h64, 4'h5, 8'h2B, 8'h02, 6'h00},
        {8'h64, 4'h5, 8'hFF, 8'hFF, 6'h3F},
        {8'h65, 4'h5, 8'h23, 8'h02, 6'h04},
        {8'h65, 4'hE, 8'h55, 8'hAA, 6'h2D},
        {8'h66, 4'h5, 8'h2B, 8'h22, 6'h00},
        {8'h66, 4'h2, 8'h2B, 8'hD4, 6'h3F},
        {8'h62, 4'h2, 8'hFF, 8'h00, 6'h2A},
        {8'h66, 4'h5, 8'h00, 8'h00, 6'h15}
    };

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        int cyc;
        logic [5:0] fl;
        logic bok;
        logic [7:0] rb;

        prog[0] = 8'h00; prog[1] = 8'h00; prog[2] = 8'h00; prog[3] = 8'h00;
        repeat (3) @(negedge clk);
        chk(flags == 6'h00, "R12 reset flags", flags, 0);
        chk(!busy && !done && !illegal, "R12 reset outputs", {busy, done, illegal}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [7:0] op, d, m, dst_a, msk_a, res;
            logic [3:0] pg;
            logic [5:0] fi, fe;
            int ncyc;
            {op, pg, d, m, fi} = VEC[i];
            wr_page = pg;
            res = ~d & m;
            msk_a = 8'h00;
            dst_a = 8'h00;
            case (op)
                8'h62: begin
                    dst_a = {pg, 4'h3}; msk_a = {pg, 4'h4};
                    prog[0] = op; prog[1] = 8'h34;
                    rf_put(dst_a, d); rf_put(msk_a, m);
                end
                8'h63: begin
                    dst_a = {pg, 4'h3}; msk_a = 8'hA0;
                    prog[0] = op; prog[1] = 8'h36;
                    rf_put(dst_a, d); rf_put({pg, 4'h6}, msk_a); rf_put(msk_a, m);
                end
                8'h64: begin
                    dst_a = 8'h82; msk_a = 8'h81;
                    prog[0] = op; prog[1] = msk_a; prog[2] = dst_a;
                    rf_put(dst_a, d); rf_put(msk_a, m);
                end
                8'h65: begin
                    dst_a = 8'h82; msk_a = 8'hA4;
                    prog[0] = op; prog[1] = 8'h83; prog[2] = dst_a;
                    rf_put(dst_a, d); rf_put(8'h83, msk_a); rf_put(msk_a, m);
                end
                default: begin
                    dst_a = 8'h82;
                    prog[0] = op; prog[1] = dst_a; prog[2] = m;
                    rf_put(dst_a, d);
                end
            endcase
            flags_put(fi);
            ncyc = (op == 8'h62) ? 4 : 6;
            run(cyc, fl, bok);
            // cycle counts: R4 (0x62), R5 (0x63), R6 (0x64), R7 (0x65), R8 (0x66)
            chk(cyc == ncyc, $sformatf("R4/R5/R6/R7/R8 op %0h cycles", op), cyc, ncyc);
            fe = {fi[5], (res == 8'h00), res[7], 1'b0, fi[1], fi[0]};
            chk(fl[4] == fe[4], $sformatf("R1 Z op %0h vec %0d", op, i), fl[4], fe[4]);
            chk(fl[3] == fe[3], $sformatf("R2 S op %0h vec %0d", op, i), fl[3], fe[3]);
            chk({fl[5], fl[2:0]} == {fe[5], fe[2:0]}, $sformatf("R3 C/V/D/H vec %0d", i),
                {fl[5], fl[2:0]}, {fe[5], fe[2:0]});
            chk(bok, "R12 busy during instruction", bok, 1);
            if (op == 8'h62 || op == 8'h63) begin
                chk(fl == fe, $sformatf("R9 page %0h flags", pg), fl, fe);
            end
            @(negedge clk);
            chk(!done && !busy, "R12 done single pulse", {done, busy}, 0);
            peek(dst_a, rb);
            chk(rb == d, "R10 destination unchanged", rb, d);
            if (op != 8'h66) begin
                peek(msk_a, rb);
                chk(rb == m, "R10 mask unchanged", rb, m);
            end
        end

        // R11: unsupported opcodes on both sides of the legal range
        for (int k = 0; k < 2; k++) begin
            logic [7:0] bad;
            logic seen_done;
            bad = (k == 0) ? 8'h61 : 8'h67;
            prog[0] = bad; prog[1] = 8'h34; prog[2] = 8'h00;
            flags_put(6'h15);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(!illegal, "R11 illegal low in cycle 1", illegal, 0);
            @(negedge clk);
            chk(illegal, $sformatf("R11 illegal in cycle 2 op %0h", bad), illegal, 1);
            seen_done = 1'b0;
            for (int j = 0; j < 8; j++) begin
                if (done) seen_done = 1'b1;
                @(negedge clk);
            end
            chk(!seen_done, "R11 no done", seen_done, 0);
            chk(!illegal && !busy, "R11 back to idle", {illegal, busy}, 0);
            chk(flags == 6'h15, "R11 flags unchanged", flags, 6'h15);
        end

        summary();
        $finish;
    end

endmodule